// File: doc/BRIEF.md
# Reservation Station Bank with Broadcast Wakeup

This block holds the instructions of one functional-unit class that have left in-order issue but have not yet finished executing. Each entry keeps an operation code and two source operands. An operand is held either as a value or as the tag of the station that will produce it. A waiting operand is filled by watching a shared result broadcast, which carries a data word and the tag of the station that produced it. When an entry holds both of its values, it competes for the class's pipelined execution unit. The entry stays allocated until its own result appears on the broadcast.

The issue stage presents one instruction per cycle and sees `iss_ready` together with the tag the instruction will be renamed to. The execution unit takes one operation per cycle through a valid/ready pair and returns, through the external broadcast path, a result labelled with `ex_tag`. Each bank takes a base tag, so the tags of all banks in the machine are nonzero and do not overlap. The default configuration is a three-entry adder bank with tags 1 to 3.

Top module: `rs_bank`

## Requirements
- R1: After a synchronous active-low reset, every entry is free: `busy` is all zeros, `full` is low, `iss_ready` is high and `ex_valid` is low.
- R2: An issue (`iss_valid` high while `iss_ready` is high) writes the lowest-index free entry and sets its `busy` bit on the next cycle. While any entry is free, `iss_tag` equals `BASE_TAG` plus the index of that entry.
- R3: When every entry is busy, `full` is high and `iss_ready` is low. An issue request in that state changes no entry.
- R4: A source tag of zero means that the value given with it is the operand. A nonzero source tag means the operand is still to be produced by that station.
- R5: In one cycle, every busy entry whose waiting operand tag equals a valid broadcast tag copies the broadcast data into that operand and sets the operand's tag to zero.
- R6: If an issuing operand's nonzero tag matches a valid broadcast in the same cycle, the entry stores the broadcast data with a zero tag.
- R7: An entry is presented on `ex_valid` only when it is busy, has not already been dispatched, and both of its operand tags are zero.
- R8: Among the presented entries, the lowest index drives the execution outputs. It is dispatched only in a cycle where `ex_ready` is high, and at most one entry is dispatched per cycle. A dispatched entry is no longer presented but stays busy.
- R9: A valid broadcast whose tag equals a busy entry's own tag frees that entry on the next cycle.
- R10: While `ex_valid` is high, `ex_op`, `ex_src1` and `ex_src2` carry the selected entry's operation and operand values, and `ex_tag` carries its station tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code of the issued instruction |
| iss_src1_tag | input | 4 | Producer tag of source 1, zero when the value is present |
| iss_src1_val | input | 64 | Value of source 1 |
| iss_src2_tag | input | 4 | Producer tag of source 2, zero when the value is present |
| iss_src2_val | input | 64 | Value of source 2 |
| iss_ready | output | 1 | At least one entry is free |
| iss_tag | output | 4 | Tag that an issue in this cycle is given |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 4 | Tag of the station whose result is broadcast |
| cdb_data | input | 64 | Broadcast result data |
| ex_valid | output | 1 | An entry is ready to execute |
| ex_ready | input | 1 | Execution unit accepts an operation this cycle |
| ex_op | output | 4 | Operation of the selected entry |
| ex_src1 | output | 64 | Source 1 value of the selected entry |
| ex_src2 | output | 64 | Source 2 value of the selected entry |
| ex_tag | output | 4 | Station tag of the selected entry |
| busy | output | 3 | Per-entry occupied flags |
| full | output | 1 | Every entry is occupied |

## Verification
The hardest situation to reach from the ports is an issue and a broadcast that both name the same producer tag in the same cycle. If the entry stored the tag instead of the value, it would wait forever, and this would only show as a missing `ex_valid` several cycles later. The bench drives that collision on each operand in turn. It then checks that the bank waits only for the other operand and presents the captured data. A second case that is hard to see is a rejected issue into a full bank. For that, the bank is filled with entries that all wait on one tag, and the bench shows that no entry was overwritten: `ex_valid` must stay low until that tag is broadcast, and the entries must then drain in index order with their original operands. A sweep covers every pairing of present, first-producer and second-producer operands. It broadcasts the producers in order and checks the presented values against data computed from the sweep index.

// File: rtl/rs_pkg.sv
// Package rs_pkg
// Shared widths and types for the reservation station bank.
// Assumes: tag value zero is reserved to mean "operand value present".
package rs_pkg;

    parameter int RS_DATA_W = 64;
    parameter int RS_TAG_W  = 4;
    parameter int RS_OP_W   = 4;

    typedef logic [RS_DATA_W-1:0] data_t;
    typedef logic [RS_TAG_W-1:0]  tag_t;
    typedef logic [RS_OP_W-1:0]   op_t;

    // One source operand: pending producer tag, or a value once tag is zero.
    typedef struct packed {
        tag_t  tag;
        data_t val;
    } operand_t;

    // Returns the operand after snooping one broadcast: a waiting operand
    // whose tag matches a valid broadcast takes the data and clears its tag.
    function automatic operand_t rs_snoop(operand_t cur, logic bvalid,
                                          tag_t btag, data_t bdata);
        operand_t nxt;
        nxt = cur;
        if (bvalid && (cur.tag != '0) && (cur.tag == btag)) begin
            nxt.tag = '0;
            nxt.val = bdata;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rs_alloc.sv
// Module rs_alloc
// Picks the lowest-index free entry for the issue port, produces the
// one-hot write enable, the tag the new entry is given, and full/ready.
// Assumes: ENTRIES >= 2 and BASE_TAG + ENTRIES - 1 fits in a tag.
module rs_alloc
    import rs_pkg::*;
#(
    parameter int ENTRIES  = 3,
    parameter int BASE_TAG = 1
) (
    input  logic [ENTRIES-1:0] busy_i,
    input  logic               iss_valid_i,
    output logic [ENTRIES-1:0] alloc_o,
    output logic               iss_ready_o,
    output tag_t               iss_tag_o,
    output logic               full_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]   free_idx;
    logic               any_free;

    // Priority search for the lowest free slot (scan high to low).
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // One-hot write enable for the chosen slot, gated by the request.
    always_comb begin
        alloc_o = '0;
        if (iss_valid_i && any_free) begin
            alloc_o[free_idx] = 1'b1;
        end
    end

    assign iss_ready_o = any_free;
    assign full_o      = &busy_i;
    assign iss_tag_o   = tag_t'(BASE_TAG + int'(free_idx));

    always_comb begin
        AST_ALLOC_TARGETS_FREE: assert ((alloc_o & busy_i) == '0); // R2
    end

endmodule

// File: rtl/rs_entry.sv
// Module rs_entry
// One reservation station: busy flag, operation, two operands with
// producer tags, and a dispatched flag. Snoops the broadcast bus for
// operand wakeup and for its own tag, which releases the entry.
// Assumes: alloc_i is only asserted while the entry is free, grant_i only
// while ready_o is high, and broadcast tags are never zero.
module rs_entry
    import rs_pkg::*;
#(
    parameter int MY_TAG = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     alloc_i,
    input  op_t      iss_op_i,
    input  operand_t iss_a_i,
    input  operand_t iss_b_i,
    input  logic     cdb_valid_i,
    input  tag_t     cdb_tag_i,
    input  data_t    cdb_data_i,
    input  logic     grant_i,
    output logic     busy_o,
    output logic     ready_o,
    output op_t      op_o,
    output operand_t a_o,
    output operand_t b_o
);

    localparam tag_t OWN_TAG = tag_t'(MY_TAG);

    logic     busy_q;
    logic     sent_q;
    op_t      op_q;
    operand_t a_q;
    operand_t b_q;
    logic     own_hit;

    assign own_hit = cdb_valid_i && (cdb_tag_i == OWN_TAG);

    // Entry state: allocate, wake up operands, mark dispatch, free on own tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            op_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            op_q   <= iss_op_i;
            a_q    <= rs_snoop(iss_a_i, cdb_valid_i, cdb_tag_i, cdb_data_i);
            b_q    <= rs_snoop(iss_b_i, cdb_valid_i, cdb_tag_i, cdb_data_i);
        end else if (busy_q) begin
            if (own_hit) begin
                busy_q <= 1'b0;
                sent_q <= 1'b0;
            end else begin
                a_q <= rs_snoop(a_q, cdb_valid_i, cdb_tag_i, cdb_data_i);
                b_q <= rs_snoop(b_q, cdb_valid_i, cdb_tag_i, cdb_data_i);
                if (grant_i) begin
                    sent_q <= 1'b1;
                end
            end
        end
    end

    assign ready_o = busy_q && !sent_q && (a_q.tag == '0) && (b_q.tag == '0);
    assign busy_o  = busy_q;
    assign op_o    = op_q;
    assign a_o     = a_q;
    assign b_o     = b_q;

    AST_FREE_ON_OWN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && own_hit && !alloc_i) |=> !busy_q); // R9

    AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !alloc_i && !own_hit && cdb_valid_i && (a_q.tag != '0)
         && (a_q.tag == cdb_tag_i))
        |=> ((a_q.tag == '0) && (a_q.val == $past(cdb_data_i)))); // R5

    AST_WAKE_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !alloc_i && !own_hit && cdb_valid_i && (b_q.tag != '0)
         && (b_q.tag == cdb_tag_i))
        |=> ((b_q.tag == '0) && (b_q.val == $past(cdb_data_i)))); // R5

    AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> ready_o); // R8

    AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !own_hit) |=> (busy_q && !ready_o)); // R8

endmodule

// File: rtl/rs_select.sv
// Module rs_select
// Chooses the lowest-index ready entry, drives the execution-unit
// outputs from it and returns a one-hot grant when the unit accepts.
// Assumes: ENTRIES >= 2; ready_i already excludes dispatched entries.
module rs_select
    import rs_pkg::*;
#(
    parameter int ENTRIES  = 3,
    parameter int BASE_TAG = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] ready_i,
    input  op_t                op_i  [ENTRIES],
    input  operand_t           a_i   [ENTRIES],
    input  operand_t           b_i   [ENTRIES],
    input  logic               ex_ready_i,
    output logic [ENTRIES-1:0] grant_o,
    output logic               ex_valid_o,
    output op_t                ex_op_o,
    output data_t              ex_a_o,
    output data_t              ex_b_o,
    output tag_t               ex_tag_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] sel_idx;
    logic             any_ready;

    // Priority search for the lowest ready slot (scan high to low).
    always_comb begin
        sel_idx   = '0;
        any_ready = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ready_i[i]) begin
                sel_idx   = IDX_W'(i);
                any_ready = 1'b1;
            end
        end
    end

    // Grant the selected slot when the execution unit takes it.
    always_comb begin
        grant_o = '0;
        if (any_ready && ex_ready_i) begin
            grant_o[sel_idx] = 1'b1;
        end
    end

    // Operation and operand mux towards the execution unit.
    always_comb begin
        ex_op_o = op_i[sel_idx];
        ex_a_o  = a_i[sel_idx].val;
        ex_b_o  = b_i[sel_idx].val;
    end

    assign ex_valid_o = any_ready;
    assign ex_tag_o   = tag_t'(BASE_TAG + int'(sel_idx));

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R8

    AST_NO_GRANT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ready_i |-> (grant_o == '0)); // R8

endmodule

// File: rtl/rs_bank.sv
// Module rs_bank
// Reservation station bank for one functional-unit class. Issue writes
// the lowest free entry; entries snoop a tagged result broadcast for their
// operands and for their own release; the lowest ready entry is offered to
// a pipelined execution unit with a valid/ready pair.
// Assumes: broadcast tags are nonzero and unique across all banks; each
// entry's own tag is broadcast only after that entry was dispatched.
module rs_bank
    import rs_pkg::*;
#(
    parameter int ENTRIES  = 3,
    parameter int BASE_TAG = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_TAG_W-1:0]  iss_src1_tag,
    input  logic [RS_DATA_W-1:0] iss_src1_val,
    input  logic [RS_TAG_W-1:0]  iss_src2_tag,
    input  logic [RS_DATA_W-1:0] iss_src2_val,
    output logic                 iss_ready,
    output logic [RS_TAG_W-1:0]  iss_tag,
    input  logic                 cdb_valid,
    input  logic [RS_TAG_W-1:0]  cdb_tag,
    input  logic [RS_DATA_W-1:0] cdb_data,
    output logic                 ex_valid,
    input  logic                 ex_ready,
    output logic [RS_OP_W-1:0]   ex_op,
    output logic [RS_DATA_W-1:0] ex_src1,
    output logic [RS_DATA_W-1:0] ex_src2,
    output logic [RS_TAG_W-1:0]  ex_tag,
    output logic [ENTRIES-1:0]   busy,
    output logic                 full
);

    localparam int LAST_TAG = BASE_TAG + ENTRIES - 1;

    initial begin
        if (ENTRIES < 2 || BASE_TAG < 1 || LAST_TAG >= (1 << RS_TAG_W)) begin
            $error("rs_bank: tag range does not fit the tag width");
        end
    end

    logic [ENTRIES-1:0] alloc;
    logic [ENTRIES-1:0] ready;
    logic [ENTRIES-1:0] grant;
    op_t                ent_op [ENTRIES];
    operand_t           ent_a  [ENTRIES];
    operand_t           ent_b  [ENTRIES];
    operand_t           iss_a;
    operand_t           iss_b;

    // Pack the issue operands into the shared operand type.
    always_comb begin
        iss_a.tag = iss_src1_tag;
        iss_a.val = iss_src1_val;
        iss_b.tag = iss_src2_tag;
        iss_b.val = iss_src2_val;
    end

    rs_alloc #(
        .ENTRIES  (ENTRIES),
        .BASE_TAG (BASE_TAG)
    ) u_alloc (
        .busy_i      (busy),
        .iss_valid_i (iss_valid),
        .alloc_o     (alloc),
        .iss_ready_o (iss_ready),
        .iss_tag_o   (iss_tag),
        .full_o      (full)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        rs_entry #(
            .MY_TAG (BASE_TAG + g)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc[g]),
            .iss_op_i    (iss_op),
            .iss_a_i     (iss_a),
            .iss_b_i     (iss_b),
            .cdb_valid_i (cdb_valid),
            .cdb_tag_i   (cdb_tag),
            .cdb_data_i  (cdb_data),
            .grant_i     (grant[g]),
            .busy_o      (busy[g]),
            .ready_o     (ready[g]),
            .op_o        (ent_op[g]),
            .a_o         (ent_a[g]),
            .b_o         (ent_b[g])
        );

        AST_DISPATCH_OPERANDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_valid && (ex_tag == tag_t'(BASE_TAG + g)))
            |-> (busy[g] && (ent_a[g].tag == '0) && (ent_b[g].tag == '0))); // R7

        AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_ready && (iss_tag == tag_t'(BASE_TAG + g)))
            |=> busy[g]); // R2
    end

    rs_select #(
        .ENTRIES  (ENTRIES),
        .BASE_TAG (BASE_TAG)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready),
        .op_i       (ent_op),
        .a_i        (ent_a),
        .b_i        (ent_b),
        .ex_ready_i (ex_ready),
        .grant_o    (grant),
        .ex_valid_o (ex_valid),
        .ex_op_o    (ex_op),
        .ex_a_o     (ex_src1),
        .ex_b_o     (ex_src2),
        .ex_tag_o   (ex_tag)
    );

    AST_FULL_STALLS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($countones(busy) <= $past($countones(busy)))); // R3

    AST_FULL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !iss_ready); // R3

endmodule

// File: tb/tb_rs_bank.sv
`timescale 1ns/1ps
// Bench for rs_bank: sweeps operand source combinations, the full bank,
// same-cycle capture at issue and dispatch ordering. Expected values are
// computed from the sweep indices.
module tb_rs_bank;
    import rs_pkg::*;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    op_t         iss_op = '0;
    tag_t        iss_src1_tag = '0;
    data_t       iss_src1_val = '0;
    tag_t        iss_src2_tag = '0;
    data_t       iss_src2_val = '0;
    logic        iss_ready;
    tag_t        iss_tag;
    logic        cdb_valid = 1'b0;
    tag_t        cdb_tag = '0;
    data_t       cdb_data = '0;
    logic        ex_valid;
    logic        ex_ready = 1'b0;
    op_t         ex_op;
    data_t       ex_src1;
    data_t       ex_src2;
    tag_t        ex_tag;
    logic [N-1:0] busy;
    logic        full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rs_bank #(.ENTRIES(N), .BASE_TAG(1)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src1_tag(iss_src1_tag), .iss_src1_val(iss_src1_val),
        .iss_src2_tag(iss_src2_tag), .iss_src2_val(iss_src2_val),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .ex_valid(ex_valid), .ex_ready(ex_ready),
        .ex_op(ex_op), .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_tag(ex_tag),
        .busy(busy), .full(full)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input op_t op, input tag_t t1, input data_t v1,
                         input tag_t t2, input data_t v2);
        iss_valid = 1'b1; iss_op = op;
        iss_src1_tag = t1; iss_src1_val = v1;
        iss_src2_tag = t2; iss_src2_val = v2;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input tag_t t, input data_t d);
        cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
        tick();
        cdb_valid = 1'b0;
    endtask

    task automatic dispatch_one();
        ex_ready = 1'b1;
        tick();
        ex_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tag_t  sel [3];
        sel[0] = 4'd0; sel[1] = 4'd4; sel[2] = 4'd5;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 full", 64'(full), 64'd0);
        chk("R1 iss_ready", 64'(iss_ready), 64'd1);
        chk("R1 ex_valid", 64'(ex_valid), 64'd0);
        chk("R2 iss_tag empty", 64'(iss_tag), 64'd1);

        // R4 R5 R7 R9 R10 sweep over operand sources
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                int k;
                data_t d4, d5, e1, e2;
                k  = a * 3 + b;
                d4 = 64'hA000_0000 + 64'(k);
                d5 = 64'hB000_0000 + 64'(k);
                e1 = (a == 0) ? 64'h1000 + 64'(k) : ((a == 1) ? d4 : d5);
                e2 = (b == 0) ? 64'h2000 + 64'(k) : ((b == 1) ? d4 : d5);
                issue(op_t'(k), sel[a], (a == 0) ? 64'h1000 + 64'(k) : 64'hDEAD,
                      sel[b], (b == 0) ? 64'h2000 + 64'(k) : 64'hBEEF);
                chk("R2 busy after issue", 64'(busy), 64'b001);
                chk("R4 R7 ready at issue", 64'(ex_valid), 64'((a == 0) && (b == 0)));
                bcast(4'd4, d4);
                chk("R5 ready after tag4", 64'(ex_valid), 64'((a != 2) && (b != 2)));
                bcast(4'd5, d5);
                chk("R5 ex_valid", 64'(ex_valid), 64'd1);
                chk("R10 ex_src1", ex_src1, e1);
                chk("R10 ex_src2", ex_src2, e2);
                chk("R10 ex_op", 64'(ex_op), 64'(k));
                chk("R10 ex_tag", 64'(ex_tag), 64'd1);
                dispatch_one();
                chk("R8 not presented after dispatch", 64'(ex_valid), 64'd0);
                chk("R8 still busy after dispatch", 64'(busy), 64'b001);
                bcast(4'd1, 64'h0);
                chk("R9 freed", 64'(busy), 64'd0);
            end
        end

        // R3 fill the bank with entries waiting on tag 4
        for (int i = 0; i < N; i++) begin
            chk("R2 iss_tag lowest free", 64'(iss_tag), 64'(i + 1));
            issue(op_t'(i + 8), 4'd4, 64'h0, 4'd0, 64'(i + 100));
        end
        chk("R3 full", 64'(full), 64'd1);
        chk("R3 iss_ready low", 64'(iss_ready), 64'd0);
        chk("R3 busy all", 64'(busy), 64'b111);
        issue(op_t'(15), 4'd0, 64'h77, 4'd0, 64'h88);
        chk("R3 rejected issue changed nothing", 64'(ex_valid), 64'd0);
        ex_ready = 1'b1;
        tick();
        ex_ready = 1'b0;
        chk("R7 waiting entries not dispatched", 64'(ex_valid), 64'd0);
        bcast(4'd4, 64'hCAFE);
        // R8 hold while execution unit is not ready
        for (int h = 0; h < 3; h++) begin
            chk("R8 hold ex_valid", 64'(ex_valid), 64'd1);
            chk("R8 hold tag", 64'(ex_tag), 64'd1);
            tick();
        end
        // R5 R8 lowest index first, one per cycle
        ex_ready = 1'b1;
        for (int i = 0; i < N; i++) begin
            chk("R8 order tag", 64'(ex_tag), 64'(i + 1));
            chk("R5 all woke src1", ex_src1, 64'hCAFE);
            chk("R3 original src2", ex_src2, 64'(i + 100));
            chk("R10 op", 64'(ex_op), 64'(i + 8));
            tick();
        end
        ex_ready = 1'b0;
        chk("R8 drained", 64'(ex_valid), 64'd0);
        bcast(4'd2, 64'h0);
        chk("R9 middle freed", 64'(busy), 64'b101);
        chk("R3 full cleared", 64'(full), 64'd0);
        chk("R2 iss_tag middle", 64'(iss_tag), 64'd2);
        issue(op_t'(3), 4'd0, 64'h31, 4'd0, 64'h32);
        chk("R2 refill middle", 64'(busy), 64'b111);
        chk("R10 refill tag", 64'(ex_tag), 64'd2);
        dispatch_one();
        bcast(4'd1, 64'h0);
        bcast(4'd2, 64'h0);
        bcast(4'd3, 64'h0);
        chk("R9 all freed", 64'(busy), 64'd0);

        // R6 same-cycle capture on each operand in turn
        for (int s = 0; s < 2; s++) begin
            cdb_valid = 1'b1; cdb_tag = 4'd4; cdb_data = 64'h5A5A + 64'(s);
            issue(op_t'(1), (s == 0) ? 4'd4 : 4'd5, 64'h0,
                  (s == 0) ? 4'd5 : 4'd4, 64'h0);
            cdb_valid = 1'b0;
            chk("R6 waits only for other", 64'(ex_valid), 64'd0);
            bcast(4'd5, 64'h6B6B);
            chk("R6 ready", 64'(ex_valid), 64'd1);
            chk("R6 src1", ex_src1, (s == 0) ? 64'h5A5A : 64'h6B6B);
            chk("R6 src2", ex_src2, (s == 0) ? 64'h6B6B : 64'h5A5B);
            dispatch_one();
            bcast(4'd1, 64'h0);
            chk("R9 freed after R6", 64'(busy), 64'd0);
        end

        // R1 reset clears occupied entries
        issue(op_t'(2), 4'd4, 64'h0, 4'd0, 64'h1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 reset clears busy", 64'(busy), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule